// File: doc/BRIEF.md
# Local Bus Arbiter with Refresh Queue

This block decides who drives a shared local memory bus: the master graphics processor, or an external agent that asks for the bus with an active-low high-priority request or an active-low low-priority request. A third active-low wire, the grant-in enable, must be low before the master may hand the bus out at all. The master also has two duties that cannot wait forever: memory refresh and display shift-register transfers. Refresh ticks add to a saturating queue of pending refresh cycles. A display-transfer-due pulse sets a pending flag. Either one can pull the bus back from an external agent.

Ownership is decided only at a memory-cycle boundary, which the cycle-done strobe marks. With a shared clock, the bus can therefore change hands on every memory cycle, and no cycle is ever cut short. Memory timing generation lies outside the block. The owner code tells the memory sequencer what kind of cycle comes next.

Top module: `lbus_arbiter`

## Requirements
- R1: After reset the owner code is 0 (master), the pending-refresh count is 0, `gnt_out_n` is 1 and `force_reclaim` is 0.
- R2: The owner code (0 master, 1 refresh cycle, 2 display transfer, 3 external agent) changes only at a clock edge where `cycle_done` is 1. The new value is visible from that edge on.
- R3: Each cycle with `refresh_tick` high adds one to the pending-refresh count. The count saturates at DEPTH (default 12).
- R4: Each `cycle_done` while the owner is 1 removes one pending refresh. A tick in that same cycle is still added, so the count is unchanged.
- R5: A `xfer_due` pulse leaves a display transfer pending. At the next `cycle_done` the owner becomes 2, ahead of every other choice. The pending flag clears at the `cycle_done` that ends the transfer cycle.
- R6: At a `cycle_done`, a full queue (count, after any drain in that cycle, equal to DEPTH) selects owner 1 ahead of any external request.
- R7: At a `cycle_done`, a high-priority request (`req_hi_n` 0) selects owner 3 ahead of a partly filled queue. A low-priority request (`req_lo_n` 0) selects owner 3 only when the drained count is 0. Otherwise a non-zero count selects owner 1.
- R8: While `grant_in_n` is 1, no `cycle_done` selects owner 3. Requests are then ignored, and the choice falls to refresh, or to master when nothing is pending.
- R9: `gnt_out_n` is 0 exactly while the owner is 3.
- R10: `force_reclaim` is 1 while the owner is 3 and either the count equals DEPTH or a display transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_hi_n | input | 1 | High-priority bus request, active low |
| req_lo_n | input | 1 | Low-priority bus request, active low |
| grant_in_n | input | 1 | Outward-grant enable, active low |
| refresh_tick | input | 1 | One refresh interval elapsed |
| xfer_due | input | 1 | Display shift-register transfer needed |
| cycle_done | input | 1 | Current memory cycle ends this clock |
| owner | output | 2 | Bus owner code for the next cycle |
| gnt_out_n | output | 1 | Bus granted to external agent, active low |
| pend_cnt | output | CW | Pending refresh count |
| force_reclaim | output | 1 | External owner must give the bus back |

## Verification
A wrong refresh count shows first on `pend_cnt`, in the cycle after the tick or drain that went wrong. It shows again at the next `cycle_done`, where it picks between refresh and an external request, so a bad count also appears on `owner` and `gnt_out_n`. A lost or sticky display-transfer flag is seen on `force_reclaim` straight away while an external agent owns the bus. It is also seen on `owner` at the next cycle boundary. Ownership that moves without `cycle_done` appears on `owner` in the very cycle it happens.

// File: rtl/lba_pkg.sv
package lba_pkg;
   typedef enum logic [1:0] {
      OWN_MST = 2'd0,
      OWN_RFS = 2'd1,
      OWN_XFR = 2'd2,
      OWN_EXT = 2'd3
   } owner_e;
endpackage

// File: rtl/lba_refresh_q.sv
module lba_refresh_q #(
   parameter int DEPTH = 12,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          drain,
   output logic [CW-1:0] cnt_q,
   output logic          any_left,
   output logic          full_left
);
   localparam logic [CW-1:0] TOP = CW'(DEPTH);

   logic [CW-1:0] cnt_ad;
   logic [CW-1:0] cnt_nx;

   // count after this cycle's drain, used for the ownership choice
   always_comb begin
      cnt_ad = drain ? (cnt_q - 1'b1) : cnt_q;
      cnt_nx = (tick && (cnt_ad != TOP)) ? (cnt_ad + 1'b1) : cnt_ad;
   end

   assign any_left  = (cnt_ad != '0);
   assign full_left = (cnt_ad == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/lba_xfer_flag.sv
module lba_xfer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_p,
   input  logic clr,
   output logic pend_q,
   output logic pend_eff
);
   assign pend_eff = pend_q & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_eff | set_p;
   end
endmodule

// File: rtl/lba_pick.sv
module lba_pick
   import lba_pkg::*;
(
   input  logic   xfer,
   input  logic   full,
   input  logic   any,
   input  logic   hi,
   input  logic   lo,
   output owner_e nxt
);
   always_comb begin
      if (xfer)           nxt = OWN_XFR;
      else if (full)      nxt = OWN_RFS;
      else if (hi)        nxt = OWN_EXT;
      else if (any)       nxt = OWN_RFS;
      else if (lo)        nxt = OWN_EXT;
      else                nxt = OWN_MST;
   end
endmodule

// File: rtl/lbus_arbiter.sv
module lbus_arbiter
   import lba_pkg::*;
#(
   parameter int DEPTH = 12,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_hi_n,
   input  logic          req_lo_n,
   input  logic          grant_in_n,
   input  logic          refresh_tick,
   input  logic          xfer_due,
   input  logic          cycle_done,
   output logic [1:0]    owner,
   output logic          gnt_out_n,
   output logic [CW-1:0] pend_cnt,
   output logic          force_reclaim
);
   localparam logic [CW-1:0] TOP = CW'(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("lbus_arbiter: DEPTH must be at least 1");
      end
      if ((1 << CW) <= DEPTH) begin : g_bad_cw
         $error("lbus_arbiter: CW too narrow for DEPTH");
      end
   endgenerate

   owner_e owner_q;
   owner_e owner_nx;
   logic   drain, xclr;
   logic   any_left, full_left;
   logic   xfer_pend, xfer_eff;
   logic   hi_ok, lo_ok;

   assign drain = cycle_done && (owner_q == OWN_RFS);
   assign xclr  = cycle_done && (owner_q == OWN_XFR);
   assign hi_ok = ~req_hi_n & ~grant_in_n;
   assign lo_ok = ~req_lo_n & ~grant_in_n;

   lba_refresh_q #(.DEPTH(DEPTH), .CW(CW)) u_rq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (refresh_tick),
      .drain     (drain),
      .cnt_q     (pend_cnt),
      .any_left  (any_left),
      .full_left (full_left)
   );

   lba_xfer_flag u_xf (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_p    (xfer_due),
      .clr      (xclr),
      .pend_q   (xfer_pend),
      .pend_eff (xfer_eff)
   );

   lba_pick u_pk (
      .xfer (xfer_eff),
      .full (full_left),
      .any  (any_left),
      .hi   (hi_ok),
      .lo   (lo_ok),
      .nxt  (owner_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          owner_q <= OWN_MST;
      else if (cycle_done) owner_q <= owner_nx;
   end

   assign owner         = owner_q;
   assign gnt_out_n     = (owner_q != OWN_EXT);
   assign force_reclaim = (owner_q == OWN_EXT) && ((pend_cnt == TOP) || xfer_pend);
endmodule

// File: rtl/lba_checker.sv
module lba_checker #(
   parameter int DEPTH = 12,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cycle_done,
   input logic          refresh_tick,
   input logic          grant_in_n,
   input logic [1:0]    owner,
   input logic [CW-1:0] pend_cnt,
   input logic          xfer_pend
);
   a_r2_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_done |=> $stable(owner));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= CW'(DEPTH));

   a_r4_drain_one: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && owner == 2'd1 && !refresh_tick) |=> (pend_cnt == CW'($past(pend_cnt) - 1'b1)));

   a_r5_xfer_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && xfer_pend && owner != 2'd2) |=> (owner == 2'd2));

   a_r6_full_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && owner != 2'd1 && !xfer_pend && pend_cnt == CW'(DEPTH)) |=> (owner == 2'd1));

   a_r8_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_done && grant_in_n) |=> (owner != 2'd3));
endmodule

bind lbus_arbiter lba_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cycle_done   (cycle_done),
   .refresh_tick (refresh_tick),
   .grant_in_n   (grant_in_n),
   .owner        (owner),
   .pend_cnt     (pend_cnt),
   .xfer_pend    (xfer_pend)
);

// File: tb/sim_lbus_arbiter.sv
`timescale 1ns/1ps
module sim_lbus_arbiter;
   localparam int DEPTH = 12;
   localparam int CW    = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, req_hi_n, req_lo_n, grant_in_n, refresh_tick, xfer_due, cycle_done;
   logic [1:0]    owner;
   logic          gnt_out_n;
   logic [CW-1:0] pend_cnt;
   logic          force_reclaim;

   lbus_arbiter #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .req_hi_n(req_hi_n), .req_lo_n(req_lo_n),
      .grant_in_n(grant_in_n), .refresh_tick(refresh_tick), .xfer_due(xfer_due),
      .cycle_done(cycle_done), .owner(owner), .gnt_out_n(gnt_out_n),
      .pend_cnt(pend_cnt), .force_reclaim(force_reclaim)
   );

   int    checks = 0;
   int    failures = 0;
   string phase = "R1";

   // behavioural reference state
   int m_own = 0;
   int m_cnt = 0;
   bit m_xp  = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_own = 0; m_cnt = 0; m_xp = 0;
      end else begin
         int  cad;
         bit  xe, hi, lo;
         cad = m_cnt - ((cycle_done && m_own == 1) ? 1 : 0);
         xe  = m_xp && !(cycle_done && m_own == 2);
         hi  = !req_hi_n && !grant_in_n;
         lo  = !req_lo_n && !grant_in_n;
         if (cycle_done) begin
            if (xe)                   m_own = 2;
            else if (cad == DEPTH)    m_own = 1;
            else if (hi)              m_own = 3;
            else if (cad > 0)         m_own = 1;
            else if (lo)              m_own = 3;
            else                      m_own = 0;
         end
         if (refresh_tick && cad < DEPTH) cad = cad + 1;
         m_cnt = cad;
         m_xp  = xe || xfer_due;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(phase, "owner", int'(owner), m_own);
         chk(phase, "pend_cnt", int'(pend_cnt), m_cnt);
         chk("R9", "gnt_out_n", int'(gnt_out_n), (m_own == 3) ? 0 : 1);
         chk("R10", "force_reclaim", int'(force_reclaim),
             (m_own == 3 && (m_cnt == DEPTH || m_xp)) ? 1 : 0);
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=0", wd);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic done_pulse();
      cycle_done = 1'b1; cyc(1); cycle_done = 1'b0; cyc(1);
   endtask

   initial begin
      rst_n = 1'b0; req_hi_n = 1'b1; req_lo_n = 1'b1; grant_in_n = 1'b0;
      refresh_tick = 1'b0; xfer_due = 1'b0; cycle_done = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      // R1: reset values seen on the first sampled cycle
      @(negedge clk); #2;
      chk("R1", "owner after reset", int'(owner), 0);
      chk("R1", "count after reset", int'(pend_cnt), 0);
      chk("R1", "gnt_out_n after reset", int'(gnt_out_n), 1);
      chk("R1", "force after reset", int'(force_reclaim), 0);
      cyc(2);

      // R3: fill past the limit
      phase = "R3";
      refresh_tick = 1'b1; cyc(14); refresh_tick = 1'b0; cyc(1);
      chk("R3", "saturated count", int'(pend_cnt), DEPTH);

      // R2: requests without cycle_done leave ownership alone
      phase = "R2";
      req_hi_n = 1'b0; cyc(5);
      chk("R2", "owner without done", int'(owner), 0);

      // R6: full queue beats the high request
      phase = "R6";
      done_pulse();
      chk("R6", "owner full queue", int'(owner), 1);

      // R4 then R7: drain one, high request takes the bus
      phase = "R7";
      done_pulse();
      chk("R4", "count after drain", int'(pend_cnt), DEPTH - 1);
      chk("R7", "high request granted", int'(owner), 3);

      // R10: queue refills while external owns the bus
      phase = "R10";
      refresh_tick = 1'b1; cyc(1); refresh_tick = 1'b0; cyc(1);
      chk("R10", "force on full", int'(force_reclaim), 1);
      done_pulse();
      // R4: tick and drain together
      phase = "R4";
      refresh_tick = 1'b1; cycle_done = 1'b1; cyc(1);
      refresh_tick = 1'b0; cycle_done = 1'b0; cyc(1);
      chk("R4", "tick with drain", int'(pend_cnt), DEPTH);

      // R5: display transfer beats everything
      phase = "R5";
      xfer_due = 1'b1; cyc(1); xfer_due = 1'b0; cyc(1);
      done_pulse();
      chk("R5", "transfer owner", int'(owner), 2);
      done_pulse();
      chk("R5", "after transfer", int'(owner), 1);

      // R7: low request waits for an empty queue
      phase = "R7";
      req_hi_n = 1'b1; req_lo_n = 1'b0;
      for (int i = 0; i < 14; i++) done_pulse();
      chk("R7", "low request after drain", int'(owner), 3);
      chk("R7", "queue empty", int'(pend_cnt), 0);

      // R8: grant-in high blocks outward grant
      phase = "R8";
      grant_in_n = 1'b1; req_hi_n = 1'b0;
      done_pulse();
      chk("R8", "blocked grant", int'(owner), 0);
      chk("R8", "gnt_out_n blocked", int'(gnt_out_n), 1);
      grant_in_n = 1'b0; req_hi_n = 1'b1; req_lo_n = 1'b1;
      done_pulse();

      // mixed traffic
      phase = "R2";
      for (int i = 0; i < 3000; i++) begin
         cycle_done   = ($urandom_range(0, 2) == 0);
         refresh_tick = ($urandom_range(0, 5) == 0);
         xfer_due     = ($urandom_range(0, 31) == 0);
         req_hi_n     = ($urandom_range(0, 2) != 0);
         req_lo_n     = ($urandom_range(0, 1) != 0);
         grant_in_n   = ($urandom_range(0, 7) == 0);
         cyc(1);
      end
      cycle_done = 1'b0; refresh_tick = 1'b0; xfer_due = 1'b0;
      cyc(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule